// File: doc/BRIEF.md
# Variable Page Size Translation Cache

This block is a small, fully associative cache of address translations. Each entry holds a virtual page number, a physical page number, a region identifier and its own encoded page size. The page size is a 6-bit exponent N, and the entry covers 2^N bytes. Because the low N bits of an address are the offset within the page, the tag compare ignores a different number of low bits in every entry. Those offset bits pass unchanged from the virtual address to the physical address.

Software, or a control unit, uses three operations. An insert writes a new translation. A lookup presents a virtual address together with the identifier of its region and returns a registered result one cycle later: hit, physical address and page size. A purge removes every translation in the same region that overlaps a given virtual range.

Inserts and purges accept different sets of sizes. A bad size is handled differently for each operation. A bad insert faults and changes nothing. A bad purge flushes the whole cache. A purge that a remote agent sent is never allowed to report a fault.

Top module: `vps_tcache`

## Requirements
- R1: After a synchronous active-low reset, no entry is valid. `lk_hit`, `ins_fault` and `pur_fault` read 0, and every lookup misses.
- R2: An insert is accepted only when `ins_ps` is one of 12, 13, 14, 16, 18, 20, 22, 24, 26 or 28. Any other value, including 32, changes no entry and sets `ins_fault` high for exactly the cycle after the request. A legal insert leaves `ins_fault` low.
- R3: A lookup with `lk_valid` high returns its result one cycle later. The lookup hits when a valid entry has the same region identifier and the same virtual address bits at and above that entry's page size. On a hit, `lk_pa` is the entry's physical bits at and above the page size, joined with the lookup address bits below it, and `lk_ps` is the entry's page size.
- R4: An entry whose region identifier differs from `lk_rid` never produces a hit, even when the addresses match.
- R5: An insert writes the lowest-numbered invalid entry. When all 8 entries are valid, it writes the entry named by a round-robin pointer. The pointer starts at entry 0 after reset and moves to the next entry, wrapping, only on such a replacement.
- R6: A purge with `pur_ps` in the insert set or equal to 32 invalidates every valid entry that has the same region identifier and whose page overlaps the purged range. Overlap is decided by comparing the address bits at and above the larger of the two page sizes. Such a purge never sets `pur_fault`.
- R7: A purge with any other size invalidates every entry, whatever its region. When `pur_remote` is 0, it also sets `pur_fault` high for the cycle after the request. When `pur_remote` is 1, `pur_fault` stays low.
- R8: When more than one entry matches a lookup, the lowest-numbered matching entry supplies `lk_pa` and `lk_ps`.
- R9: When an insert and a purge arrive in the same cycle, the purge acts on the existing entries. The new entry is written after the purge and stays valid. Its slot is chosen from the contents as they were before the purge.
- R10: In the cycle after a cycle in which `lk_valid` is low, `lk_hit` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_va | input | VA_W | Virtual address of the new page |
| ins_rid | input | RID_W | Region identifier of the new page |
| ins_pa | input | PA_W | Physical address of the new page |
| ins_ps | input | 6 | Page size exponent of the new page |
| ins_fault | output | 1 | Unsupported insert size, one cycle after the request |
| lk_valid | input | 1 | Lookup request |
| lk_va | input | VA_W | Virtual address to translate |
| lk_rid | input | RID_W | Region identifier of the address |
| lk_hit | output | 1 | Registered lookup hit |
| lk_pa | output | PA_W | Registered translated address |
| lk_ps | output | 6 | Registered page size of the hit entry |
| pur_valid | input | 1 | Purge request |
| pur_va | input | VA_W | Base of the purged range |
| pur_rid | input | RID_W | Region identifier of the purged range |
| pur_ps | input | 6 | Size exponent of the purged range |
| pur_remote | input | 1 | Purge was sent by another agent |
| pur_fault | output | 1 | Unsupported local purge size, one cycle after the request |

## Verification
Lookups are tried against a 4 KB page and a 256 MB page. Addresses inside and just outside each page show that the masked width follows each entry's own size, and a changed region identifier shows that the tag includes the region. Purges are aimed at a range that misses a large page, a range inside a large page, a range in another region, and a 4 GB range. These patterns tell apart comparing at the larger size from comparing at either single size. Fill-and-overflow sequences, duplicate pages of different sizes and a simultaneous insert and purge tell free-slot-first apart from pure round-robin, and show both the match priority and the order of operations within a cycle.

// File: rtl/vtc_pkg.sv
// Package: shared constants and page-size legality checks for the
// variable page size translation cache.
// Assumes page sizes are 6-bit exponents (page = 2^ps bytes).
package vtc_pkg;

    localparam int PS_W = 6;

    // True when a page size may be written into the cache by an insert.
    function automatic logic ps_insert_ok(input logic [PS_W-1:0] ps);
        return ps inside {6'd12, 6'd13, 6'd14, 6'd16, 6'd18,
                          6'd20, 6'd22, 6'd24, 6'd26, 6'd28};
    endfunction

    // True when a purge of this size is handled selectively (insert set plus 4G).
    function automatic logic ps_purge_ok(input logic [PS_W-1:0] ps);
        return ps_insert_ok(ps) || (ps == 6'd32);
    endfunction

endpackage

// File: rtl/vtc_entry.sv
// Module: vtc_entry
// One cache entry. It holds a translation and reports, combinationally,
// whether it matches the current lookup and the current purge request.
// Assumes the top never asserts wr_en for two entries in one cycle;
// a write takes priority over a clear in the same cycle.
module vtc_entry
    import vtc_pkg::*;
#(
    parameter int VA_W  = 40,
    parameter int PA_W  = 40,
    parameter int RID_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [VA_W-1:0]  wr_va,
    input  logic [RID_W-1:0] wr_rid,
    input  logic [PA_W-1:0]  wr_pa,
    input  logic [PS_W-1:0]  wr_ps,
    input  logic             clr,
    input  logic [VA_W-1:0]  lk_va,
    input  logic [RID_W-1:0] lk_rid,
    input  logic [VA_W-1:0]  pur_va,
    input  logic [RID_W-1:0] pur_rid,
    input  logic [PS_W-1:0]  pur_ps,
    output logic             valid,
    output logic             lk_match,
    output logic             pur_match,
    output logic [PA_W-1:0]  ent_pa,
    output logic [PS_W-1:0]  ent_ps
);

    logic [VA_W-1:0]  va_q;
    logic [RID_W-1:0] rid_q;
    logic [PS_W-1:0]  big_ps;
    logic [VA_W-1:0]  page_mask;
    logic [VA_W-1:0]  range_mask;

    // Entry storage: reset clears, write loads, purge clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid  <= 1'b0;
            va_q   <= '0;
            rid_q  <= '0;
            ent_pa <= '0;
            ent_ps <= '0;
        end else if (wr_en) begin
            valid  <= 1'b1;
            va_q   <= wr_va;
            rid_q  <= wr_rid;
            ent_pa <= wr_pa;
            ent_ps <= wr_ps;
        end else if (clr) begin
            valid  <= 1'b0;
        end
    end

    // Tag compares: lookup masks at the entry size, purge at the larger size.
    always_comb begin
        big_ps     = (ent_ps > pur_ps) ? ent_ps : pur_ps;
        page_mask  = {VA_W{1'b1}} << ent_ps;
        range_mask = {VA_W{1'b1}} << big_ps;
        lk_match   = valid && (rid_q == lk_rid)
                     && (((va_q ^ lk_va) & page_mask) == '0);
        pur_match  = valid && (rid_q == pur_rid)
                     && (((va_q ^ pur_va) & range_mask) == '0);
    end

    assert_write_sets_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> valid);

endmodule

// File: rtl/vtc_victim.sv
// Module: vtc_victim
// Chooses the entry an insert will write: the lowest invalid entry if
// any, otherwise a round-robin pointer that advances on each replacement.
// Assumes 'advance' is high only in cycles where an insert is accepted.
module vtc_victim #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               advance,
    output logic [ENTRIES-1:0] sel
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] free_idx;
    logic             full;
    logic [IDX_W-1:0] sel_idx;

    // Find the lowest-numbered free entry.
    always_comb begin
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) free_idx = IDX_W'(i);
        end
        full    = &valid_vec;
        sel_idx = full ? rr_q : free_idx;
        sel     = ENTRIES'(1) << sel_idx;
    end

    // Round-robin pointer, moved only when a valid entry is replaced.
    always_ff @(posedge clk) begin
        if (!rst_n)              rr_q <= '0;
        else if (advance && full) rr_q <= (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end

    assert_sel_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(sel));
    assert_free_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !full |-> ((sel & valid_vec) == '0));

endmodule

// File: rtl/vtc_select.sv
// Module: vtc_select
// Priority selector: the lowest-numbered matching entry supplies the
// translated page bits and the page size.
// Assumes the match vector is already qualified by each entry's valid bit.
module vtc_select
    import vtc_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int PA_W    = 40
) (
    input  logic [ENTRIES-1:0]            match_vec,
    input  logic [ENTRIES-1:0][PA_W-1:0]  pa_vec,
    input  logic [ENTRIES-1:0][PS_W-1:0]  ps_vec,
    output logic                          hit,
    output logic [PA_W-1:0]               pa,
    output logic [PS_W-1:0]               ps
);

    // Scan from the top so the lowest matching index is applied last.
    always_comb begin
        hit = |match_vec;
        pa  = '0;
        ps  = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                pa = pa_vec[i];
                ps = ps_vec[i];
            end
        end
    end

endmodule

// File: rtl/vps_tcache.sv
// Module: vps_tcache
// Fully associative translation cache with a page size per entry and a
// region identifier tag. It supports insert, lookup (result registered one
// cycle later) and range purge. Insert and purge finish in one cycle.
// Assumes the caller keeps pages aligned to their size. Within a cycle
// the purge acts first, then the insert is written.
module vps_tcache
    import vtc_pkg::*;
#(
    parameter int VA_W    = 40,
    parameter int PA_W    = 40,
    parameter int RID_W   = 24,
    parameter int ENTRIES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [VA_W-1:0]  ins_va,
    input  logic [RID_W-1:0] ins_rid,
    input  logic [PA_W-1:0]  ins_pa,
    input  logic [5:0]       ins_ps,
    output logic             ins_fault,
    input  logic             lk_valid,
    input  logic [VA_W-1:0]  lk_va,
    input  logic [RID_W-1:0] lk_rid,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_pa,
    output logic [5:0]       lk_ps,
    input  logic             pur_valid,
    input  logic [VA_W-1:0]  pur_va,
    input  logic [RID_W-1:0] pur_rid,
    input  logic [5:0]       pur_ps,
    input  logic             pur_remote,
    output logic             pur_fault
);

    logic [ENTRIES-1:0]            valid_vec;
    logic [ENTRIES-1:0]            lk_match_vec;
    logic [ENTRIES-1:0]            pur_match_vec;
    logic [ENTRIES-1:0]            victim;
    logic [ENTRIES-1:0][PA_W-1:0]  pa_vec;
    logic [ENTRIES-1:0][PS_W-1:0]  ps_vec;
    logic                          ins_ok;
    logic                          pur_ok;
    logic                          ins_do;
    logic                          sel_hit;
    logic [PA_W-1:0]               sel_pa;
    logic [PS_W-1:0]               sel_ps;
    logic [PA_W-1:0]               low_mask;
    logic [PA_W-1:0]               xlat_pa;

    // Size legality for the two writing operations.
    always_comb begin
        ins_ok = ps_insert_ok(ins_ps);
        pur_ok = ps_purge_ok(pur_ps);
        ins_do = ins_valid && ins_ok;
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        vtc_entry #(.VA_W(VA_W), .PA_W(PA_W), .RID_W(RID_W)) entry_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (ins_do && victim[g]),
            .wr_va     (ins_va),
            .wr_rid    (ins_rid),
            .wr_pa     (ins_pa),
            .wr_ps     (ins_ps),
            .clr       (pur_valid && (!pur_ok || pur_match_vec[g])),
            .lk_va     (lk_va),
            .lk_rid    (lk_rid),
            .pur_va    (pur_va),
            .pur_rid   (pur_rid),
            .pur_ps    (pur_ps),
            .valid     (valid_vec[g]),
            .lk_match  (lk_match_vec[g]),
            .pur_match (pur_match_vec[g]),
            .ent_pa    (pa_vec[g]),
            .ent_ps    (ps_vec[g])
        );
    end

    vtc_victim #(.ENTRIES(ENTRIES)) victim_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_vec (valid_vec),
        .advance   (ins_do),
        .sel       (victim)
    );

    vtc_select #(.ENTRIES(ENTRIES), .PA_W(PA_W)) select_i (
        .match_vec (lk_match_vec),
        .pa_vec    (pa_vec),
        .ps_vec    (ps_vec),
        .hit       (sel_hit),
        .pa        (sel_pa),
        .ps        (sel_ps)
    );

    // Join the page bits of the entry with the offset bits of the address.
    always_comb begin
        low_mask = ~({PA_W{1'b1}} << sel_ps);
        xlat_pa  = (sel_pa & ~low_mask) | (PA_W'(lk_va) & low_mask);
    end

    // Register the lookup result and the two fault pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit    <= 1'b0;
            lk_pa     <= '0;
            lk_ps     <= '0;
            ins_fault <= 1'b0;
            pur_fault <= 1'b0;
        end else begin
            lk_hit    <= lk_valid && sel_hit;
            lk_pa     <= xlat_pa;
            lk_ps     <= sel_ps;
            ins_fault <= ins_valid && !ins_ok;
            pur_fault <= pur_valid && !pur_ok && !pur_remote;
        end
    end

    assert_bad_insert_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && !ps_insert_ok(ins_ps) && !pur_valid) |=> (ins_fault && $stable(valid_vec)));
    assert_fault_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ins_fault |-> $past(ins_valid));
    assert_remote_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pur_valid && pur_remote) |=> !pur_fault);
    assert_bad_purge_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pur_valid && !ps_purge_ok(pur_ps) && !ins_valid) |=> (valid_vec == '0));
    assert_hit_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> $past(lk_valid));
    assert_ok_purge_no_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pur_valid && ps_purge_ok(pur_ps)) |=> !pur_fault);

endmodule

// File: tb/vps_tcache_tb_top.sv
// Directed bench for vps_tcache: one task per scenario, each checking itself.
module vps_tcache_tb_top;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ins_valid = 1'b0;
    logic [39:0] ins_va = '0;
    logic [23:0] ins_rid = '0;
    logic [39:0] ins_pa = '0;
    logic [5:0]  ins_ps = '0;
    logic        ins_fault;
    logic        lk_valid = 1'b0;
    logic [39:0] lk_va = '0;
    logic [23:0] lk_rid = '0;
    logic        lk_hit;
    logic [39:0] lk_pa;
    logic [5:0]  lk_ps;
    logic        pur_valid = 1'b0;
    logic [39:0] pur_va = '0;
    logic [23:0] pur_rid = '0;
    logic [5:0]  pur_ps = '0;
    logic        pur_remote = 1'b0;
    logic        pur_fault;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_P / 2) clk = ~clk;

    vps_tcache dut_i (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_va(ins_va), .ins_rid(ins_rid),
        .ins_pa(ins_pa), .ins_ps(ins_ps), .ins_fault(ins_fault),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_rid(lk_rid),
        .lk_hit(lk_hit), .lk_pa(lk_pa), .lk_ps(lk_ps),
        .pur_valid(pur_valid), .pur_va(pur_va), .pur_rid(pur_rid),
        .pur_ps(pur_ps), .pur_remote(pur_remote), .pur_fault(pur_fault)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Advance to one time unit after the next rising edge.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_insert(input logic [39:0] va, input logic [23:0] rid,
                             input logic [39:0] pa, input logic [5:0] ps,
                             input bit exp_fault, input string req);
        ins_valid = 1'b1; ins_va = va; ins_rid = rid; ins_pa = pa; ins_ps = ps;
        tick();
        ins_valid = 1'b0;
        check(ins_fault == exp_fault, req, 64'(ins_fault), 64'(exp_fault));
    endtask

    task automatic do_purge(input logic [39:0] va, input logic [23:0] rid,
                            input logic [5:0] ps, input bit remote,
                            input bit exp_fault, input string req);
        pur_valid = 1'b1; pur_va = va; pur_rid = rid; pur_ps = ps; pur_remote = remote;
        tick();
        pur_valid = 1'b0; pur_remote = 1'b0;
        check(pur_fault == exp_fault, req, 64'(pur_fault), 64'(exp_fault));
    endtask

    task automatic do_lookup(input logic [39:0] va, input logic [23:0] rid,
                             input bit exp_hit, input logic [39:0] exp_pa,
                             input logic [5:0] exp_ps, input string req);
        lk_valid = 1'b1; lk_va = va; lk_rid = rid;
        tick();
        lk_valid = 1'b0;
        check(lk_hit == exp_hit, {req, " hit"}, 64'(lk_hit), 64'(exp_hit));
        if (exp_hit) begin
            check(lk_pa == exp_pa, {req, " pa"}, 64'(lk_pa), 64'(exp_pa));
            check(lk_ps == exp_ps, {req, " ps"}, 64'(lk_ps), 64'(exp_ps));
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    // R1: state right after reset.
    task automatic t_reset();
        check(lk_hit == 1'b0, "R1 lk_hit", 64'(lk_hit), 64'd0);
        check(ins_fault == 1'b0, "R1 ins_fault", 64'(ins_fault), 64'd0);
        check(pur_fault == 1'b0, "R1 pur_fault", 64'(pur_fault), 64'd0);
        do_lookup(40'h0, 24'd0, 1'b0, '0, '0, "R1 empty lookup");
    endtask

    // R3, R4, R10: basic translation at two page sizes.
    task automatic t_lookup();
        do_insert(40'h00_1234_5000, 24'd5, 40'h00_ABCD_E000, 6'd12, 1'b0, "R2 legal 4K");
        do_insert(40'h00_4000_0000, 24'd5, 40'h90_0000_0000, 6'd28, 1'b0, "R2 legal 256M");
        do_lookup(40'h00_1234_5678, 24'd5, 1'b1, 40'h00_ABCD_E678, 6'd12, "R3 4K hit");
        tick();
        check(lk_hit == 1'b0, "R10 idle lookup", 64'(lk_hit), 64'd0);
        do_lookup(40'h00_1234_6000, 24'd5, 1'b0, '0, '0, "R3 next 4K page");
        do_lookup(40'h00_4ABC_DEF0, 24'd5, 1'b1, 40'h90_0ABC_DEF0, 6'd28, "R3 256M hit");
        do_lookup(40'h00_5000_0000, 24'd5, 1'b0, '0, '0, "R3 beyond 256M");
        do_lookup(40'h00_1234_5678, 24'd6, 1'b0, '0, '0, "R4 other region");
    endtask

    // R2: unsupported insert sizes fault and add nothing.
    task automatic t_bad_insert();
        do_insert(40'h00_7000_0000, 24'd5, 40'h00_1111_0000, 6'd15, 1'b1, "R2 size 15");
        do_insert(40'h00_7000_0000, 24'd5, 40'h00_1111_0000, 6'd32, 1'b1, "R2 size 32");
        check(ins_fault == 1'b1, "R2 fault already set", 64'(ins_fault), 64'd1);
        tick();
        check(ins_fault == 1'b0, "R2 fault one cycle", 64'(ins_fault), 64'd0);
        do_lookup(40'h00_7000_0000, 24'd5, 1'b0, '0, '0, "R2 nothing inserted");
        do_lookup(40'h00_1234_5000, 24'd5, 1'b1, 40'h00_ABCD_E000, 6'd12, "R2 old entry kept");
    endtask

    // R6: selective purges at the larger of the two sizes.
    task automatic t_purge();
        do_purge(40'h00_1234_5000, 24'd5, 6'd12, 1'b0, 1'b0, "R6 purge 4K");
        do_lookup(40'h00_1234_5000, 24'd5, 1'b0, '0, '0, "R6 4K gone");
        do_lookup(40'h00_4000_0000, 24'd5, 1'b1, 40'h90_0000_0000, 6'd28, "R6 256M kept");
        do_purge(40'h00_4123_4000, 24'd7, 6'd14, 1'b0, 1'b0, "R6 other region purge");
        do_lookup(40'h00_4000_0000, 24'd5, 1'b1, 40'h90_0000_0000, 6'd28, "R6 region protects");
        do_purge(40'h00_4123_4000, 24'd5, 6'd14, 1'b0, 1'b0, "R6 purge inside 256M");
        do_lookup(40'h00_4000_0000, 24'd5, 1'b0, '0, '0, "R6 256M gone");
        do_insert(40'h01_2000_0000, 24'd5, 40'h00_0200_0000, 6'd24, 1'b0, "R6 setup a");
        do_insert(40'h02_0000_0000, 24'd5, 40'h00_0300_0000, 6'd12, 1'b0, "R6 setup b");
        do_purge(40'h01_0000_0000, 24'd5, 6'd32, 1'b1, 1'b0, "R6 purge 4G");
        do_lookup(40'h01_2000_0000, 24'd5, 1'b0, '0, '0, "R6 4G removes");
        do_lookup(40'h02_0000_0010, 24'd5, 1'b1, 40'h00_0300_0010, 6'd12, "R6 4G spares");
    endtask

    // R7: unsupported purge size flushes everything; fault only when local.
    task automatic t_bad_purge();
        do_insert(40'h00_0800_0000, 24'd9, 40'h00_0900_0000, 6'd16, 1'b0, "R7 setup");
        do_purge(40'h00_0000_0000, 24'd1, 6'd15, 1'b0, 1'b1, "R7 local fault");
        do_lookup(40'h00_0800_0000, 24'd9, 1'b0, '0, '0, "R7 local flush");
        do_lookup(40'h02_0000_0000, 24'd5, 1'b0, '0, '0, "R7 local flush all");
        do_insert(40'h00_0800_0000, 24'd9, 40'h00_0900_0000, 6'd16, 1'b0, "R7 setup 2");
        do_purge(40'h00_0000_0000, 24'd1, 6'd40, 1'b1, 1'b0, "R7 remote no fault");
        do_lookup(40'h00_0800_0000, 24'd9, 1'b0, '0, '0, "R7 remote flush");
    endtask

    // R5: free slot first, then round robin from entry 0.
    task automatic t_replace();
        for (int i = 0; i < 8; i++)
            do_insert(40'h10_0000 + 40'(i) * 40'h1000, 24'd1,
                      40'h20_0000 + 40'(i) * 40'h1000, 6'd12, 1'b0, "R5 fill");
        do_insert(40'h18_0000, 24'd1, 40'h28_0000, 6'd12, 1'b0, "R5 ninth");
        do_lookup(40'h10_0000, 24'd1, 1'b0, '0, '0, "R5 slot0 replaced");
        do_lookup(40'h10_1000, 24'd1, 1'b1, 40'h20_1000, 6'd12, "R5 slot1 kept");
        do_lookup(40'h18_0000, 24'd1, 1'b1, 40'h28_0000, 6'd12, "R5 ninth present");
        do_insert(40'h19_0000, 24'd1, 40'h29_0000, 6'd12, 1'b0, "R5 tenth");
        do_lookup(40'h10_1000, 24'd1, 1'b0, '0, '0, "R5 slot1 replaced");
        do_purge(40'h10_3000, 24'd1, 6'd12, 1'b0, 1'b0, "R5 free slot3");
        do_insert(40'h1A_0000, 24'd1, 40'h2A_0000, 6'd12, 1'b0, "R5 into hole");
        do_lookup(40'h10_2000, 24'd1, 1'b1, 40'h20_2000, 6'd12, "R5 hole used not rr");
        do_lookup(40'h1A_0000, 24'd1, 1'b1, 40'h2A_0000, 6'd12, "R5 hole entry");
    endtask

    // R8: lowest matching entry wins.
    task automatic t_priority();
        do_purge(40'h0, 24'd0, 6'd0, 1'b1, 1'b0, "R8 flush");
        do_insert(40'h30_0000, 24'd2, 40'h11_1000, 6'd12, 1'b0, "R8 small");
        do_insert(40'h30_0000, 24'd2, 40'h50_0000, 6'd20, 1'b0, "R8 large");
        do_lookup(40'h30_0ABC, 24'd2, 1'b1, 40'h11_1ABC, 6'd12, "R8 lowest wins");
        do_lookup(40'h3F_0000, 24'd2, 1'b1, 40'h5F_0000, 6'd20, "R8 only large");
    endtask

    // R9: purge and insert in the same cycle.
    task automatic t_same_cycle();
        pur_valid = 1'b1; pur_va = 40'h30_0000; pur_rid = 24'd2; pur_ps = 6'd20;
        ins_valid = 1'b1; ins_va = 40'h30_0000; ins_rid = 24'd2;
        ins_pa = 40'h77_7000; ins_ps = 6'd12;
        tick();
        pur_valid = 1'b0; ins_valid = 1'b0;
        check(ins_fault == 1'b0 && pur_fault == 1'b0, "R9 no fault",
              64'({ins_fault, pur_fault}), 64'd0);
        do_lookup(40'h30_0123, 24'd2, 1'b1, 40'h77_7123, 6'd12, "R9 insert survives");
        do_lookup(40'h3F_0000, 24'd2, 1'b0, '0, '0, "R9 old purged");
    endtask

    initial begin
        #(CLK_P * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        tick();
        t_reset();
        t_lookup();
        t_bad_insert();
        t_purge();
        t_bad_purge();
        t_replace();
        t_priority();
        t_same_cycle();
        finish_run();
    end

endmodule